// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Sequencer

This block produces the per-cycle fractional offset that a PLL feedback divider adds to its integer ratio. It runs at the phase-detector rate. When modulation is on, it walks a programmable table of sigma-delta-encoded samples. Each sample is held for a programmable number of cycles. The table is played forward, then backward, then forward and backward again with the sign negated. Together these four quarters make one modulation period with a symmetric, triangle-like shape.

A base offset shifts the whole profile. With a base of zero the spread is centred on the nominal ratio. With a non-zero base the nominal integer ratio is lowered by software and the profile sits below it as a down spread. The same base offset, with modulation disabled, gives a plain fractional divide. One field combination would drive the downstream modulator unstable. The block flags that combination and forces its output to zero.

Configuration is captured only on a write strobe. Every write restarts the profile from its first sample.

Top module: `ssc_profile_seq`

## Requirements
- R1: After reset the captured configuration is all zero, the dither generator holds 7'h01, `frac_ofs` is 0, and `cfg_illegal` and `prd_start` are 0.
- R2: While the profile runs (`hold_sel` > 0, `mod_en` = 1, `samp_cnt` > 0), each sample's contribution stays on the output for exactly `hold_sel` + 2 consecutive cycles.
- R3: One quarter contains 2 × `samp_cnt` samples, and a period is 4 × 2 × `samp_cnt` × (`hold_sel` + 2) cycles. `prd_start` is 1 exactly in the first cycle of each period.
- R4: Quarter 0 uses table entries 0 up to N−1, and quarter 1 uses them from N−1 down to 0. Quarters 2 and 3 repeat that order with the sample negated. Entry k sits at bits [6k+5:6k] of `samp_tbl`.
- R5: While running, `frac_ofs` (9-bit two's complement) equals `ofs_base` plus the signed sample term plus the dither bit. With `ofs_base` = 0 and `amp_dbl` = 0 and no dither, the output therefore stays within ±63.
- R6: With `amp_dbl` = 1 the sample magnitude is doubled before the sign is applied, so the extremes reach ±126.
- R7: With `hold_sel` > 0, `ofs_base` = 0 and `mod_en` = 0, `cfg_illegal` is 1 and `frac_ofs` is 0 regardless of the table and of dither.
- R8: With a legal configuration and the profile not running (`hold_sel` = 0, `mod_en` = 0, or `samp_cnt` = 0), `frac_ofs` equals `ofs_base` every cycle. Neither dither nor the table has any effect.
- R9: A 7-bit LFSR advances every cycle from reset. The new bit 0 is the old bit 6 XOR the old bit 5, and the other bits shift up by one. While running with `dither_en` = 1, bit 0 of the current LFSR state is added to the output.
- R10: A cycle with `cfg_wr` = 1 captures all fields, and from the next cycle the profile restarts at quarter 0, sample 0. Field changes without `cfg_wr` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| hold_sel | input | 4 | Hold field; each sample lasts this value + 2 cycles, and 0 disables modulation |
| samp_cnt | input | 4 | Sample field; a quarter has twice this many samples |
| mod_en | input | 1 | Sigma-delta modulation enable |
| ofs_base | input | 6 | Base fractional offset in 1/64 units |
| amp_dbl | input | 1 | Doubles the sample amplitude |
| dither_en | input | 1 | Adds the 1-LSB pseudo-random dither |
| samp_tbl | input | 180 | Sample table, 30 entries of 6 bits |
| frac_ofs | output | 9 | Signed per-cycle offset to the feedback divider |
| cfg_illegal | output | 1 | Unstable configuration detected |
| prd_start | output | 1 | First cycle of a modulation period |

## Verification
The bench aims at the points where the mirror reverses and where the sign flips, because an off-by-one in the descending index would repeat or skip the peak sample. It drives the largest table, with N = 30 and a hold of 17, to catch a wrap counter that overflows. It drives the amplitude extremes with doubling on, where a sign-extension slip would turn −126 into a large positive value. It drives the unstable combination and the fractional-only mode with dither enabled, where a design that leaks modulation or dither would move a value that must stay flat. It also changes the fields mid-period without a write, and then writes mid-period: a design that reads the fields live would drift, and one that fails to restart would not return to sample 0.

// File: rtl/ssc_profile_seq.sv
`timescale 1ns/1ps
module ssc_profile_seq #(
  parameter int HOLD_W = 4,
  parameter int NSEL_W = 4,
  parameter int SAMP_W = 6
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_wr,
  input  logic [HOLD_W-1:0]                             hold_sel,
  input  logic [NSEL_W-1:0]                             samp_cnt,
  input  logic                                          mod_en,
  input  logic [SAMP_W-1:0]                             ofs_base,
  input  logic                                          amp_dbl,
  input  logic                                          dither_en,
  input  logic [2*((1<<NSEL_W)-1)*SAMP_W-1:0]           samp_tbl,
  output logic [SAMP_W+2:0]                             frac_ofs,
  output logic                                          cfg_illegal,
  output logic                                          prd_start
);
  localparam int MAX_N = 2*((1<<NSEL_W)-1);
  localparam int IDX_W = NSEL_W+1;
  localparam int OUT_W = SAMP_W+3;

  logic [HOLD_W-1:0] hold_r;
  logic [NSEL_W-1:0] cnt_r;
  logic              mod_r, dbl_r, dith_r;
  logic [SAMP_W-1:0] ofs_r;
  logic [SAMP_W-1:0] tbl_r [MAX_N];
  logic [1:0]        q_r;
  logic [IDX_W-1:0]  i_r;
  logic [HOLD_W:0]   h_r;
  logic [6:0]        lfsr_r;

  logic [HOLD_W:0]   hold_last;
  logic [IDX_W-1:0]  n_last, idx;
  logic              run;
  logic [SAMP_W:0]   mag;
  logic [OUT_W-1:0]  ofs_s, mag_s, term, dith_s;

  assign hold_last   = {1'b0, hold_r} + {{HOLD_W{1'b0}}, 1'b1};
  assign n_last      = {cnt_r, 1'b0} - {{(IDX_W-1){1'b0}}, 1'b1};
  assign cfg_illegal = (hold_r != '0) && (ofs_r == '0) && !mod_r;
  assign run         = (hold_r != '0) && mod_r && (cnt_r != '0);
  assign idx         = q_r[0] ? (n_last - i_r) : i_r;
  assign mag         = dbl_r ? {tbl_r[idx], 1'b0} : {1'b0, tbl_r[idx]};
  assign ofs_s       = {{(OUT_W-SAMP_W){1'b0}}, ofs_r};
  assign mag_s       = {{(OUT_W-SAMP_W-1){1'b0}}, mag};
  assign term        = q_r[1] ? (~mag_s + {{(OUT_W-1){1'b0}}, 1'b1}) : mag_s;
  assign dith_s      = {{(OUT_W-1){1'b0}}, dith_r & lfsr_r[0]};
  assign prd_start   = run && (q_r == 2'd0) && (i_r == '0) && (h_r == '0);

  always_comb begin
    if (cfg_illegal)  frac_ofs = '0;
    else if (run)     frac_ofs = ofs_s + term + dith_s;
    else              frac_ofs = ofs_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_r <= '0;
      cnt_r  <= '0;
      mod_r  <= 1'b0;
      dbl_r  <= 1'b0;
      dith_r <= 1'b0;
      ofs_r  <= '0;
      q_r    <= '0;
      i_r    <= '0;
      h_r    <= '0;
      lfsr_r <= 7'h01;
      for (int k = 0; k < MAX_N; k++) tbl_r[k] <= '0;
    end else begin
      lfsr_r <= {lfsr_r[5:0], lfsr_r[6] ^ lfsr_r[5]};
      if (cfg_wr) begin
        hold_r <= hold_sel;
        cnt_r  <= samp_cnt;
        mod_r  <= mod_en;
        dbl_r  <= amp_dbl;
        dith_r <= dither_en;
        ofs_r  <= ofs_base;
        for (int k = 0; k < MAX_N; k++) tbl_r[k] <= samp_tbl[k*SAMP_W +: SAMP_W];
        q_r <= '0;
        i_r <= '0;
        h_r <= '0;
      end else if (run) begin
        if (h_r == hold_last) begin
          h_r <= '0;
          if (i_r == n_last) begin
            i_r <= '0;
            q_r <= q_r + 2'd1;
          end else begin
            i_r <= i_r + {{(IDX_W-1){1'b0}}, 1'b1};
          end
        end else begin
          h_r <= h_r + {{HOLD_W{1'b0}}, 1'b1};
        end
      end
    end
  end
endmodule

// File: rtl/ssc_profile_seq_chk.sv
`timescale 1ns/1ps
module ssc_profile_seq_chk #(
  parameter int HOLD_W = 4,
  parameter int NSEL_W = 4,
  parameter int SAMP_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [SAMP_W+2:0] frac_ofs,
  input logic              cfg_illegal,
  input logic              prd_start,
  input logic              run,
  input logic              dith_r,
  input logic              dbl_r,
  input logic [SAMP_W-1:0] ofs_r,
  input logic [1:0]        q_r,
  input logic [NSEL_W:0]   i_r,
  input logic [HOLD_W:0]   h_r,
  input logic [HOLD_W:0]   hold_last
);
  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (frac_ofs == '0));

  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_start && !cfg_wr) |=> !prd_start);

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !dith_r && !cfg_wr && h_r != hold_last) |=> $stable(frac_ofs));

  a_r8_static_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cfg_illegal && !cfg_wr) |=> $stable(frac_ofs));

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (q_r == 2'd0 && i_r == '0 && h_r == '0));

  a_r5_center_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ofs_r == '0 && !dbl_r && !dith_r) |->
      ($signed(frac_ofs) <= 63 && $signed(frac_ofs) >= -63));
endmodule

bind ssc_profile_seq ssc_profile_seq_chk #(
  .HOLD_W(HOLD_W), .NSEL_W(NSEL_W), .SAMP_W(SAMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .frac_ofs(frac_ofs),
  .cfg_illegal(cfg_illegal), .prd_start(prd_start), .run(run),
  .dith_r(dith_r), .dbl_r(dbl_r), .ofs_r(ofs_r), .q_r(q_r), .i_r(i_r),
  .h_r(h_r), .hold_last(hold_last)
);

// File: tb/ssc_profile_seq_test.sv
`timescale 1ns/1ps
module ssc_profile_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [3:0]   hold_sel = '0, samp_cnt = '0;
  logic         mod_en = 1'b0, amp_dbl = 1'b0, dither_en = 1'b0;
  logic [5:0]   ofs_base = '0;
  logic [179:0] samp_tbl = '0;
  logic [8:0]   frac_ofs;
  logic         cfg_illegal, prd_start;

  int checks = 0, fails = 0;
  bit done = 0, chk_on = 0, freeze_ph = 0;

  // reference state
  int m_hold, m_cnt, m_mod, m_dbl, m_dith, m_ofs, m_t, m_lfsr;
  int m_tbl [30];

  always #10 clk = ~clk;

  ssc_profile_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .hold_sel(hold_sel),
    .samp_cnt(samp_cnt), .mod_en(mod_en), .ofs_base(ofs_base),
    .amp_dbl(amp_dbl), .dither_en(dither_en), .samp_tbl(samp_tbl),
    .frac_ofs(frac_ofs), .cfg_illegal(cfg_illegal), .prd_start(prd_start)
  );

  function automatic bit m_run();
    return m_hold > 0 && m_mod == 1 && m_cnt > 0;
  endfunction
  function automatic bit m_bad();
    return m_hold > 0 && m_ofs == 0 && m_mod == 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = 0; m_cnt = 0; m_mod = 0; m_dbl = 0; m_dith = 0; m_ofs = 0;
      m_t = 0; m_lfsr = 1;
      for (int k = 0; k < 30; k++) m_tbl[k] = 0;
    end else begin
      m_lfsr = ((m_lfsr << 1) & 'h7e) | (((m_lfsr >> 6) ^ (m_lfsr >> 5)) & 1);
      if (cfg_wr) begin
        m_hold = hold_sel; m_cnt = samp_cnt; m_mod = mod_en; m_dbl = amp_dbl;
        m_dith = dither_en; m_ofs = ofs_base; m_t = 0;
        for (int k = 0; k < 30; k++) m_tbl[k] = samp_tbl[k*6 +: 6];
      end else if (m_run()) m_t++;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on && !done) begin
    int hold, n, per, pos, qq, k, idx, mag, e_out, e_prd, e_bad;
    string tag;
    e_bad = m_bad(); e_prd = 0;
    if (e_bad) begin
      e_out = 0; tag = "R7";
    end else if (!m_run()) begin
      e_out = m_ofs; tag = "R8";
    end else begin
      hold = m_hold + 2; n = 2 * m_cnt; per = 4 * n * hold;
      pos = m_t % per; qq = pos / (n * hold); k = (pos % (n * hold)) / hold;
      idx = (qq % 2 == 1) ? (n - 1 - k) : k;
      mag = m_tbl[idx] * (m_dbl ? 2 : 1);
      e_out = m_ofs + ((qq >= 2) ? -mag : mag) + (m_dith ? (m_lfsr & 1) : 0);
      e_prd = (pos == 0);
      tag = "R2 R3 R4 R5";
      if (m_dbl) tag = {tag, " R6"};
      if (m_dith) tag = {tag, " R9"};
    end
    if (freeze_ph || m_t == 0) tag = {tag, " R10"};
    check(tag, $signed(frac_ofs), e_out, "frac_ofs");
    check(tag, cfg_illegal, e_bad, "cfg_illegal");
    check(tag, prd_start, e_prd, "prd_start");
  end

  task automatic fill(int base, int step);
    for (int k = 0; k < 30; k++) samp_tbl[k*6 +: 6] = 6'((base + step * k) % 64);
  endtask

  task automatic wr(int hs, int nc, int me, int ob, int ad, int de);
    @(negedge clk);
    hold_sel = 4'(hs); samp_cnt = 4'(nc); mod_en = 1'(me); ofs_base = 6'(ob);
    amp_dbl = 1'(ad); dither_en = 1'(de); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    fill(3, 5);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", $signed(frac_ofs), 0, "frac_ofs in reset");
    check("R1", cfg_illegal, 0, "cfg_illegal in reset");
    check("R1", prd_start, 0, "prd_start in reset");
    rst_n = 1'b1;
    chk_on = 1;
    repeat (4) @(negedge clk);
    // centre spread, small table
    wr(1, 2, 1, 0, 0, 0);           repeat (100) @(negedge clk);
    // amplitude extremes with doubling
    fill(63, 61);
    wr(2, 3, 1, 0, 1, 0);           repeat (160) @(negedge clk);
    // down spread, long hold
    fill(10, 7);
    wr(14, 6, 1, 20, 0, 0);         repeat (800) @(negedge clk);
    // dither
    wr(3, 4, 1, 32, 0, 1);          repeat (300) @(negedge clk);
    // unstable configuration, dither on
    wr(3, 4, 0, 0, 1, 1);           repeat (30) @(negedge clk);
    // fractional-only divide, dither on
    wr(5, 4, 0, 48, 0, 1);          repeat (30) @(negedge clk);
    // hold field zero: modulation off
    wr(0, 4, 1, 7, 1, 1);           repeat (20) @(negedge clk);
    // sample field zero: modulation off
    wr(4, 0, 1, 9, 0, 0);           repeat (20) @(negedge clk);
    // largest table and hold
    fill(1, 2);
    wr(15, 15, 1, 0, 1, 0);         repeat (2100) @(negedge clk);
    // R10: mid-period field changes without a write, then a restart
    wr(2, 5, 1, 4, 0, 0);           repeat (37) @(negedge clk);
    freeze_ph = 1;
    hold_sel = 4'd9; samp_cnt = 4'd1; ofs_base = 6'd0; mod_en = 1'b0; fill(50, 3);
    repeat (60) @(negedge clk);
    freeze_ph = 0;
    wr(6, 2, 1, 0, 0, 0);           repeat (130) @(negedge clk);
    finish_run();
  end
endmodule